// File: doc/BRIEF.md
# Bidirectional Ring Stop

One stop on a two-direction ring interconnect. Each direction runs through its own three-stage pipeline inside the stop. The stages are arrival, hold and output. A message arriving at either ring input is ejected to the local agent if it is addressed to this stop and the eject register can take it. Otherwise it travels on toward the output of the same direction, and this includes local messages that could not be ejected. Those keep circling the ring until a later pass finds the eject side ready.

The local agent injects a message with a valid/ready handshake. The stop computes the destination from an XOR hash of the request address, then sends the message clockwise or counter-clockwise, whichever needs fewer hops. A message already on the ring always wins its output slot. For that reason each direction publishes a slot-free flag one cycle before the slot it describes, and the agent may use that slot in the following cycle. A full 64-byte line travels as two 32-byte beats. Both beats go in the same direction to the same destination, and a beat index bit tells them apart. The stop makes no promise about the order of messages. Reordering is the agents' job.

Top module: `ring_stop`

## Requirements
- R1: The destination ID of an injected message is (addr[8:6] XOR addr[11:9]) modulo the stop count, which defaults to 8 stops.
- R2: An injected message leaves on the clockwise output when its clockwise hop count, (dst − local ID) mod N, is not greater than its counter-clockwise hop count. Otherwise it leaves on the counter-clockwise output. Equal counts and a zero distance both pick clockwise.
- R3: A message that arrives on a ring input and is not ejected appears on the output of the same direction exactly three clock edges later, with its dst, beat and data unchanged.
- R4: During the cycle after an edge, slot_free_<dir> is low exactly when a message was captured in that direction's arrival stage at that edge to pass through. When it is high, a request for that direction presented in the next cycle sees req_rdy high.
- R5: Ring traffic takes priority. While a pass-through message sits in the hold stage of the chosen direction, req_rdy is low, and the injection is accepted one cycle later.
- R6: An accepted single-beat request (req_vld and req_rdy at an edge) appears on the chosen output after that edge with beat = 0 and data = req_data.
- R7: When req_line = 1, the first accepted beat carries beat = 0. The next accepted beat carries beat = 1 and reuses the first beat's direction and destination, whatever req_addr is at that time. After the second beat, routing returns to the address.
- R8: A ring message whose dst equals LOCAL_ID is loaded into the eject register when the register is empty or is being drained. ej_vld and ej_data then hold steady until ej_rdy is seen high.
- R9: A local message that arrives while the eject register is full and not ready keeps circling. It appears on its own direction's output three edges later.
- R10: When local messages arrive on both inputs at the same edge, the clockwise one is ejected and the counter-clockwise one circles.
- R11: In reset, both ring outputs and ej_vld are low, and both slot-free flags and req_rdy are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_in_vld | input | 1 | Clockwise ring input valid |
| cw_in_beat | input | 1 | Clockwise input beat index |
| cw_in_dst | input | 3 | Clockwise input destination stop |
| cw_in_data | input | 256 | Clockwise input payload |
| ccw_in_vld | input | 1 | Counter-clockwise ring input valid |
| ccw_in_beat | input | 1 | Counter-clockwise input beat index |
| ccw_in_dst | input | 3 | Counter-clockwise input destination stop |
| ccw_in_data | input | 256 | Counter-clockwise input payload |
| cw_out_vld | output | 1 | Clockwise ring output valid |
| cw_out_beat | output | 1 | Clockwise output beat index |
| cw_out_dst | output | 3 | Clockwise output destination stop |
| cw_out_data | output | 256 | Clockwise output payload |
| ccw_out_vld | output | 1 | Counter-clockwise ring output valid |
| ccw_out_beat | output | 1 | Counter-clockwise output beat index |
| ccw_out_dst | output | 3 | Counter-clockwise output destination stop |
| ccw_out_data | output | 256 | Counter-clockwise output payload |
| slot_free_cw | output | 1 | Clockwise slot free in the next cycle |
| slot_free_ccw | output | 1 | Counter-clockwise slot free in the next cycle |
| req_vld | input | 1 | Local injection request valid |
| req_rdy | output | 1 | Injection accepted this cycle |
| req_addr | input | 16 | Request address used for hashing |
| req_line | input | 1 | Request is a two-beat line transfer |
| req_data | input | 256 | Injection payload (one beat) |
| ej_vld | output | 1 | Ejected message valid |
| ej_rdy | input | 1 | Local agent accepts ejected message |
| ej_beat | output | 1 | Ejected message beat index |
| ej_data | output | 256 | Ejected message payload |

## Verification
The bench targets the hop-count tie at distance four and the zero-distance self-addressed case. If the direction compare were wrong, either case would leave on the counter-clockwise output. It presents a request behind an in-flight message. A stop without ring priority would drop the pass-through message or overwrite it, and a wrong slot-free timing would accept the request one cycle early. It changes the address between the two beats of a line, so a stop that did not latch the route would send beat 1 the wrong way. It also stalls the eject side and sends local traffic in both directions at once. A design that overwrote the eject register, or ejected both messages, would lose a message or fail to recirculate one.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

    localparam int RS_STOPS  = 8;
    localparam int RS_ID_W   = $clog2(RS_STOPS);
    localparam int RS_DATA_W = 256;

    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } dir_e;

    typedef struct packed {
        logic                 vld;
        logic                 beat;
        logic [RS_ID_W-1:0]   dst;
        logic [RS_DATA_W-1:0] data;
    } flit_t;

    // destination stop from address bits 11..6
    function automatic logic [RS_ID_W-1:0] stop_hash(input logic [11:0] addr);
        int h;
        h = int'(addr[8:6] ^ addr[11:9]) % RS_STOPS;
        return RS_ID_W'(h);
    endfunction

    // shorter way round; ties and zero distance go clockwise
    function automatic dir_e pick_dir(input logic [RS_ID_W-1:0] src,
                                      input logic [RS_ID_W-1:0] dst);
        int cw;
        int ccw;
        cw  = (int'(dst) + RS_STOPS - int'(src)) % RS_STOPS;
        ccw = (RS_STOPS - cw) % RS_STOPS;
        return (cw <= ccw) ? DIR_CW : DIR_CCW;
    endfunction

endpackage

// File: rtl/rs_lane.sv
module rs_lane
    import ring_stop_pkg::*;
#(
    parameter int LOCAL_ID = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  flit_t in_f,
    input  logic  take,
    output logic  hit,
    output logic  arr_busy,
    output logic  hold_busy,
    input  logic  inj_en,
    input  flit_t inj_f,
    output flit_t out_f
);
    flit_t arr_q, hold_q, out_q;

    assign hit       = in_f.vld && (in_f.dst == RS_ID_W'(LOCAL_ID));
    assign arr_busy  = arr_q.vld;
    assign hold_busy = hold_q.vld;
    assign out_f     = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q  <= '0;
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            arr_q  <= (in_f.vld && !take) ? in_f : '0;
            hold_q <= arr_q;
            if (hold_q.vld)
                out_q <= hold_q;
            else if (inj_en)
                out_q <= inj_f;
            else
                out_q <= '0;
        end
    end
endmodule

// File: rtl/rs_eject.sv
module rs_eject
    import ring_stop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] hit,
    input  flit_t      cw_f,
    input  flit_t      ccw_f,
    input  logic       ej_rdy,
    output logic [1:0] take,
    output flit_t      ej_f
);
    flit_t ej_q;
    logic  can_load;

    assign can_load = !ej_q.vld || ej_rdy;
    assign take[0]  = hit[0] && can_load;
    assign take[1]  = hit[1] && can_load && !hit[0];
    assign ej_f     = ej_q;

    always_ff @(posedge clk) begin
        if (rst)
            ej_q <= '0;
        else if (take[0])
            ej_q <= cw_f;
        else if (take[1])
            ej_q <= ccw_f;
        else if (ej_rdy)
            ej_q <= '0;
    end
endmodule

// File: rtl/rs_inject.sv
module rs_inject
    import ring_stop_pkg::*;
#(
    parameter int LOCAL_ID = 2,
    parameter int ADDR_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_vld,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_line,
    input  logic [RS_DATA_W-1:0] req_data,
    input  logic [1:0]           hold_busy,
    output logic                 req_rdy,
    output logic [1:0]           inj_en,
    output flit_t                inj_f
);
    logic               line_act;
    dir_e               line_dir;
    logic [RS_ID_W-1:0] line_dst;
    logic [RS_ID_W-1:0] cur_dst;
    dir_e               cur_dir;
    logic               fire;

    always_comb begin
        if (line_act) begin
            cur_dst = line_dst;
            cur_dir = line_dir;
        end else begin
            cur_dst = stop_hash(req_addr[11:0]);
            cur_dir = pick_dir(RS_ID_W'(LOCAL_ID), cur_dst);
        end
        req_rdy   = (cur_dir == DIR_CW) ? !hold_busy[0] : !hold_busy[1];
        fire      = req_vld && req_rdy;
        inj_en[0] = fire && (cur_dir == DIR_CW);
        inj_en[1] = fire && (cur_dir == DIR_CCW);
        inj_f     = '{vld: 1'b1, beat: line_act, dst: cur_dst, data: req_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_act <= 1'b0;
            line_dir <= DIR_CW;
            line_dst <= '0;
        end else if (fire) begin
            if (line_act) begin
                line_act <= 1'b0;
            end else if (req_line) begin
                line_act <= 1'b1;
                line_dir <= cur_dir;
                line_dst <= cur_dst;
            end
        end
    end
endmodule

// File: rtl/ring_stop.sv
module ring_stop
    import ring_stop_pkg::*;
#(
    parameter int LOCAL_ID = 2,
    parameter int ADDR_W   = 16,
    localparam int ID_W    = RS_ID_W,
    localparam int DATA_W  = RS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_in_vld,
    input  logic              cw_in_beat,
    input  logic [ID_W-1:0]   cw_in_dst,
    input  logic [DATA_W-1:0] cw_in_data,
    input  logic              ccw_in_vld,
    input  logic              ccw_in_beat,
    input  logic [ID_W-1:0]   ccw_in_dst,
    input  logic [DATA_W-1:0] ccw_in_data,
    output logic              cw_out_vld,
    output logic              cw_out_beat,
    output logic [ID_W-1:0]   cw_out_dst,
    output logic [DATA_W-1:0] cw_out_data,
    output logic              ccw_out_vld,
    output logic              ccw_out_beat,
    output logic [ID_W-1:0]   ccw_out_dst,
    output logic [DATA_W-1:0] ccw_out_data,
    output logic              slot_free_cw,
    output logic              slot_free_ccw,
    input  logic              req_vld,
    output logic              req_rdy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              ej_vld,
    input  logic              ej_rdy,
    output logic              ej_beat,
    output logic [DATA_W-1:0] ej_data
);
    flit_t      in_f  [2];
    flit_t      out_f [2];
    flit_t      inj_f;
    flit_t      ej_f;
    logic [1:0] hit, take, arr_busy, hold_busy, inj_en;

    assign in_f[0] = '{vld: cw_in_vld,  beat: cw_in_beat,  dst: cw_in_dst,  data: cw_in_data};
    assign in_f[1] = '{vld: ccw_in_vld, beat: ccw_in_beat, dst: ccw_in_dst, data: ccw_in_data};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        rs_lane #(.LOCAL_ID(LOCAL_ID)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .in_f      (in_f[g]),
            .take      (take[g]),
            .hit       (hit[g]),
            .arr_busy  (arr_busy[g]),
            .hold_busy (hold_busy[g]),
            .inj_en    (inj_en[g]),
            .inj_f     (inj_f),
            .out_f     (out_f[g])
        );
    end

    rs_eject u_eject (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .cw_f   (in_f[0]),
        .ccw_f  (in_f[1]),
        .ej_rdy (ej_rdy),
        .take   (take),
        .ej_f   (ej_f)
    );

    rs_inject #(.LOCAL_ID(LOCAL_ID), .ADDR_W(ADDR_W)) u_inject (
        .clk       (clk),
        .rst       (rst),
        .req_vld   (req_vld),
        .req_addr  (req_addr),
        .req_line  (req_line),
        .req_data  (req_data),
        .hold_busy (hold_busy),
        .req_rdy   (req_rdy),
        .inj_en    (inj_en),
        .inj_f     (inj_f)
    );

    assign slot_free_cw  = !arr_busy[0];
    assign slot_free_ccw = !arr_busy[1];

    assign cw_out_vld   = out_f[0].vld;
    assign cw_out_beat  = out_f[0].beat;
    assign cw_out_dst   = out_f[0].dst;
    assign cw_out_data  = out_f[0].data;
    assign ccw_out_vld  = out_f[1].vld;
    assign ccw_out_beat = out_f[1].beat;
    assign ccw_out_dst  = out_f[1].dst;
    assign ccw_out_data = out_f[1].data;

    assign ej_vld  = ej_f.vld;
    assign ej_beat = ej_f.beat;
    assign ej_data = ej_f.data;
endmodule

// File: rtl/rs_chk.sv
module rs_chk
    import ring_stop_pkg::*;
#(
    parameter int LOCAL_ID = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cw_in_vld,
    input logic [RS_ID_W-1:0]   cw_in_dst,
    input logic                 cw_out_vld,
    input logic [RS_ID_W-1:0]   cw_out_dst,
    input logic                 ccw_out_vld,
    input logic                 req_vld,
    input logic                 req_rdy,
    input logic                 slot_free_cw,
    input logic                 ej_vld,
    input logic                 ej_rdy,
    input logic [RS_DATA_W-1:0] ej_data,
    input logic [1:0]           hold_busy,
    input logic [1:0]           take
);
    // R3
    pass_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (cw_in_vld && cw_in_dst != RS_ID_W'(LOCAL_ID))
        |-> ##3 (cw_out_vld && cw_out_dst == $past(cw_in_dst, 3)));

    // R4
    slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        slot_free_cw |=> !hold_busy[0]);

    // R6
    inject_out_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_rdy) |=> (cw_out_vld || ccw_out_vld));

    // R8
    eject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ej_vld && !ej_rdy) |=> (ej_vld && $stable(ej_data)));

    // R10
    single_take_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));
endmodule

bind ring_stop rs_chk #(.LOCAL_ID(LOCAL_ID)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cw_in_vld    (cw_in_vld),
    .cw_in_dst    (cw_in_dst),
    .cw_out_vld   (cw_out_vld),
    .cw_out_dst   (cw_out_dst),
    .ccw_out_vld  (ccw_out_vld),
    .req_vld      (req_vld),
    .req_rdy      (req_rdy),
    .slot_free_cw (slot_free_cw),
    .ej_vld       (ej_vld),
    .ej_rdy       (ej_rdy),
    .ej_data      (ej_data),
    .hold_busy    (hold_busy),
    .take         (take)
);

// File: tb/sim_ring_stop.sv
module sim_ring_stop;
    localparam int DW = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cw_in_vld = 0, cw_in_beat = 0, ccw_in_vld = 0, ccw_in_beat = 0;
    logic [2:0]    cw_in_dst = '0, ccw_in_dst = '0;
    logic [DW-1:0] cw_in_data = '0, ccw_in_data = '0;
    logic          cw_out_vld, cw_out_beat, ccw_out_vld, ccw_out_beat;
    logic [2:0]    cw_out_dst, ccw_out_dst;
    logic [DW-1:0] cw_out_data, ccw_out_data;
    logic          slot_free_cw, slot_free_ccw;
    logic          req_vld = 0, req_rdy, req_line = 0;
    logic [15:0]   req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          ej_vld, ej_rdy = 0, ej_beat;
    logic [DW-1:0] ej_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ring_stop u0 (.*);

    // {addr[15:0], expected dst[2:0], expected clockwise}; local stop ID = 2
    localparam logic [19:0] VEC [8] = '{
        {16'h00C0, 3'd3, 1'b1},
        {16'h01C0, 3'd7, 1'b0},
        {16'h03C0, 3'd6, 1'b1},   // tie, 4 hops each way
        {16'h0A00, 3'd5, 1'b1},
        {16'h06C0, 3'd0, 1'b0},
        {16'h04C0, 3'd1, 1'b0},
        {16'h0EC0, 3'd4, 1'b1},
        {16'h0080, 3'd2, 1'b1}    // self-addressed, zero distance
    };

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    initial begin
        #80000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!cw_out_vld && !ccw_out_vld, "R11 ring outputs", int'({cw_out_vld, ccw_out_vld}), 0);
        chk(!ej_vld, "R11 ej_vld", int'(ej_vld), 0);
        chk(slot_free_cw && slot_free_ccw && req_rdy, "R11 free/rdy",
            int'({slot_free_cw, slot_free_ccw, req_rdy}), 7);
        rst = 1'b0;

        // R1 R2 R6: table walk of single-beat injections
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_vld  = 1'b1;
            req_line = 1'b0;
            req_addr = VEC[i][19:4];
            req_data = DW'(100 + i);
            #1;
            chk(req_rdy == 1'b1, "R6 rdy idle", int'(req_rdy), 1);
            @(negedge clk);
            req_vld = 1'b0;
            if (VEC[i][0]) begin
                chk(cw_out_vld && !ccw_out_vld, "R2 clockwise", int'({cw_out_vld, ccw_out_vld}), 2);
                chk(cw_out_dst == VEC[i][3:1], "R1 dst", int'(cw_out_dst), int'(VEC[i][3:1]));
                chk(cw_out_data[31:0] == 100 + i && !cw_out_beat, "R6 data",
                    int'(cw_out_data[31:0]), 100 + i);
            end else begin
                chk(ccw_out_vld && !cw_out_vld, "R2 counter-clockwise", int'({cw_out_vld, ccw_out_vld}), 1);
                chk(ccw_out_dst == VEC[i][3:1], "R1 dst", int'(ccw_out_dst), int'(VEC[i][3:1]));
                chk(ccw_out_data[31:0] == 100 + i && !ccw_out_beat, "R6 data",
                    int'(ccw_out_data[31:0]), 100 + i);
            end
        end

        // R3 R4 R5: pass-through ahead of a clockwise injection
        @(negedge clk);
        cw_in_vld = 1'b1; cw_in_dst = 3'd5; cw_in_beat = 1'b1; cw_in_data = DW'(32'h55);
        @(negedge clk);
        cw_in_vld = 1'b0;
        chk(!slot_free_cw && slot_free_ccw, "R4 slot flags busy", int'({slot_free_cw, slot_free_ccw}), 1);
        @(negedge clk);
        chk(slot_free_cw, "R4 slot free again", int'(slot_free_cw), 1);
        req_vld = 1'b1; req_addr = 16'h00C0; req_data = DW'(32'h77);
        #1;
        chk(!req_rdy, "R5 rdy low behind ring traffic", int'(req_rdy), 0);
        @(negedge clk);
        chk(cw_out_vld && cw_out_dst == 3'd5 && cw_out_beat && cw_out_data[31:0] == 32'h55,
            "R3 pass-through", int'(cw_out_data[31:0]), 32'h55);
        #1;
        chk(req_rdy, "R5 rdy after slot clears", int'(req_rdy), 1);
        @(negedge clk);
        req_vld = 1'b0;
        chk(cw_out_vld && cw_out_dst == 3'd3 && cw_out_data[31:0] == 32'h77,
            "R5 delayed injection", int'(cw_out_data[31:0]), 32'h77);

        // R7: two-beat line, address changed for beat 1
        @(negedge clk);
        req_vld = 1'b1; req_line = 1'b1; req_addr = 16'h00C0; req_data = DW'(32'hA0);
        @(negedge clk);
        chk(cw_out_vld && !cw_out_beat && cw_out_dst == 3'd3, "R7 beat 0",
            int'({cw_out_vld, cw_out_beat}), 2);
        req_addr = 16'h01C0; req_data = DW'(32'hA1);
        @(negedge clk);
        req_vld = 1'b0; req_line = 1'b0;
        chk(cw_out_vld && !ccw_out_vld && cw_out_beat && cw_out_dst == 3'd3 &&
            cw_out_data[31:0] == 32'hA1, "R7 beat 1 locked route",
            int'({cw_out_vld, ccw_out_vld, cw_out_beat}), 5);
        @(negedge clk);
        req_vld = 1'b1; req_addr = 16'h01C0; req_data = DW'(32'hA2);
        @(negedge clk);
        req_vld = 1'b0;
        chk(ccw_out_vld && !ccw_out_beat && ccw_out_dst == 3'd7, "R7 route released",
            int'({ccw_out_vld, ccw_out_beat}), 2);

        // R8 R9: eject stalled, second local message circles
        @(negedge clk);
        ej_rdy = 1'b0;
        cw_in_vld = 1'b1; cw_in_dst = 3'd2; cw_in_beat = 1'b0; cw_in_data = DW'(32'hE1);
        @(negedge clk);
        cw_in_vld = 1'b0;
        chk(ej_vld && ej_data[31:0] == 32'hE1, "R8 eject", int'(ej_data[31:0]), 32'hE1);
        chk(slot_free_cw, "R8 ejected slot free", int'(slot_free_cw), 1);
        ccw_in_vld = 1'b1; ccw_in_dst = 3'd2; ccw_in_data = DW'(32'hE2);
        @(negedge clk);
        ccw_in_vld = 1'b0;
        chk(ej_vld && ej_data[31:0] == 32'hE1, "R8 eject holds", int'(ej_data[31:0]), 32'hE1);
        chk(!slot_free_ccw, "R9 circling occupies slot", int'(slot_free_ccw), 0);
        @(negedge clk);
        @(negedge clk);
        chk(ccw_out_vld && ccw_out_dst == 3'd2 && ccw_out_data[31:0] == 32'hE2,
            "R9 circled", int'(ccw_out_data[31:0]), 32'hE2);
        ej_rdy = 1'b1;
        @(negedge clk);
        chk(!ej_vld, "R8 drained", int'(ej_vld), 0);

        // R10: local messages on both inputs together
        @(negedge clk);
        cw_in_vld = 1'b1; cw_in_dst = 3'd2; cw_in_data = DW'(32'hD1);
        ccw_in_vld = 1'b1; ccw_in_dst = 3'd2; ccw_in_data = DW'(32'hD2);
        @(negedge clk);
        cw_in_vld = 1'b0; ccw_in_vld = 1'b0;
        chk(ej_vld && ej_data[31:0] == 32'hD1, "R10 clockwise ejected", int'(ej_data[31:0]), 32'hD1);
        chk(!slot_free_ccw && slot_free_cw, "R10 ccw circles", int'({slot_free_cw, slot_free_ccw}), 2);
        @(negedge clk);
        chk(!ej_vld, "R10 single eject", int'(ej_vld), 0);
        @(negedge clk);
        chk(ccw_out_vld && !cw_out_vld && ccw_out_data[31:0] == 32'hD2, "R10 ccw output",
            int'(ccw_out_data[31:0]), 32'hD2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule